// File: doc/BRIEF.md
# Center-Aligned PWM Timer with Period-Start Trigger

This block is a 16-bit up/down timer that produces a symmetric (center-aligned) PWM waveform on one output pin. Each period the count climbs from a programmable starting value to a programmable ceiling and then falls back to the starting value. A single compare channel sets the pin high while the count sits above the channel threshold, so the high time is centered on the count peak. An output-sense input can invert the pin.

At the start of every period the timer can emit a one-cycle pulse. A downstream delay or sequencing block uses this pulse to place sample strobes or comparison windows at fixed offsets inside the PWM period. The count rate comes from a source select, which can be off, every clock, or an external tick strobe, followed by a power-of-two prescaler. Ceiling, threshold and starting value are held in shadow copies. New values take effect only at a period start, so a mid-period change never produces a short or split pulse. A sticky period flag marks each period start and is cleared by a clear strobe.

Top module: `cpwm_timer`

## Requirements
- R1: After a synchronous reset, `count` is 0 and `pwm_out`, `init_trig` and `tof` are 0.
- R2: With ceiling M greater than start value I, the count runs I, I+1, ..., M, M-1, ..., I+1 and then restarts at I. One period is therefore 2*(M-I) count ticks, and the count never leaves [I, M].
- R3: A period starts on the tick that returns the count to the start value. On that tick the values on `mod_val`, `ch_val` and `cnt_init` are copied into the working set, and the count takes the new start value. Changes to these inputs at any other time have no effect until the next period start.
- R4: When `trig_en` is 1, `init_trig` is high for exactly the one clock in which `count` first shows the start value of a new period. When `trig_en` is 0, `init_trig` stays low.
- R5: With `pol_inv`=0, `pwm_out` is high while the count is above threshold C, and also while the count equals C on the descending half. For I < C < M the pin is therefore high for 2*(M-C) ticks per period. When C >= M the pin never goes high. `pwm_out` is valid in the same cycle as the `count` it belongs to.
- R6: With `pol_inv`=1, `pwm_out` is the inverse of the R5 level. A change of `pol_inv` shows on the pin one clock later, without waiting for a period start.
- R7: `tof` is set by every period start and cleared by `tof_clr`=1. If both happen in the same cycle, the set wins.
- R8: `clk_sel`=00 stops the timer, and the count and all outputs hold. `clk_sel`=01 gives a source pulse every clock. `clk_sel`=10 or 11 takes `ext_tick` as the source pulse.
- R9: The count advances once every 2^`presc` source pulses (`presc` 0..7). The prescaler restarts from zero while the timer is stopped.
- R10: If M <= I, every count tick is a period start and the count stays at I.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_sel | input | 2 | Count source: 00 off, 01 every clock, 1x external tick |
| ext_tick | input | 1 | External source pulse, one clock wide per pulse |
| presc | input | 3 | Prescaler exponent, divide by 2^presc |
| cnt_init | input | 16 | Start value of each period (shadowed) |
| mod_val | input | 16 | Count ceiling (shadowed) |
| ch_val | input | 16 | Compare threshold (shadowed) |
| pol_inv | input | 1 | Invert the PWM pin |
| trig_en | input | 1 | Enable the period-start pulse |
| tof_clr | input | 1 | Clear strobe for the period flag |
| count | output | 16 | Current count |
| pwm_out | output | 1 | Registered PWM level |
| init_trig | output | 1 | One-cycle period-start pulse |
| tof | output | 1 | Sticky period flag |

## Verification
Two events can fall in the same clock: the period start that sets the flag and a clear strobe from outside. A second pair is a working-set reload and an input change arriving on that same boundary tick. The bench holds `tof_clr` high across a period start. The flag must read 1 in the cycle that shows the pulse and 0 one cycle later. Ceiling and threshold are also rewritten mid-period; the running period must keep its old length and the following period must take the new one. A cycle-by-cycle period-phase model of the count, pin, pulse and flag judges both cases under directed and seeded random settings.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  typedef enum logic [1:0] {
    CS_OFF     = 2'b00,
    CS_SYS     = 2'b01,
    CS_EXT     = 2'b10,
    CS_EXT_ALT = 2'b11
  } clk_src_e;
endpackage

// File: rtl/cpwm_prescale.sv
module cpwm_prescale #(
  parameter int PSC_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             src_pulse,
  input  logic [PSC_W-1:0] presc,
  output logic             tick
);
  localparam int DIV_W = (1 << PSC_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] lim;
  logic [DIV_W:0]   pow;

  always_comb begin
    pow  = {{DIV_W{1'b0}}, 1'b1} << presc;
    lim  = DIV_W'(pow - {{DIV_W{1'b0}}, 1'b1});
    tick = run && src_pulse && (div_q >= lim);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      div_q <= '0;
    end else if (src_pulse) begin
      if (div_q >= lim) div_q <= '0;
      else              div_q <= div_q + 1'b1;
    end
  end

  // R9: with a divider above one, two ticks are never adjacent
  assert_tick_gap_R9: assert property (@(posedge clk) disable iff (rst)
    (tick && presc != '0) |=> (!tick || presc == '0));
endmodule

// File: rtl/cpwm_updown.sv
module cpwm_updown #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] init_in,
  input  logic [CNT_W-1:0] mod_in,
  input  logic [CNT_W-1:0] chv_in,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] init_q,
  output logic [CNT_W-1:0] mod_q,
  output logic [CNT_W-1:0] chv_q,
  output logic [CNT_W-1:0] cnt_n,
  output logic [CNT_W-1:0] chv_n,
  output logic             desc_n,
  output logic             bnd
);
  localparam int W1 = CNT_W + 1;

  logic             up_q, up_n;
  logic [CNT_W-1:0] init_n, mod_n;
  logic [CNT_W:0]   floor_p1;
  logic             near_floor, at_peak;

  always_comb begin
    floor_p1   = {1'b0, init_q} + W1'(1);
    near_floor = ({1'b0, cnt_q} <= floor_p1);
    at_peak    = up_q && (cnt_q >= mod_q);
    bnd        = tick && near_floor && (!up_q || at_peak);

    cnt_n  = cnt_q;
    up_n   = up_q;
    init_n = init_q;
    mod_n  = mod_q;
    chv_n  = chv_q;
    if (bnd) begin
      cnt_n  = init_in;
      up_n   = 1'b1;
      init_n = init_in;
      mod_n  = mod_in;
      chv_n  = chv_in;
    end else if (tick) begin
      if (at_peak) begin
        cnt_n = cnt_q - 1'b1;
        up_n  = 1'b0;
      end else if (up_q) begin
        cnt_n = cnt_q + 1'b1;
      end else begin
        cnt_n = cnt_q - 1'b1;
      end
    end
    desc_n = !up_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      up_q   <= 1'b1;
      init_q <= '0;
      mod_q  <= '0;
      chv_q  <= '0;
    end else begin
      cnt_q  <= cnt_n;
      up_q   <= up_n;
      init_q <= init_n;
      mod_q  <= mod_n;
      chv_q  <= chv_n;
    end
  end

  // R2: a proper period keeps the count inside [start, ceiling]
  assert_bounds_R2: assert property (@(posedge clk) disable iff (rst)
    (mod_q > init_q) |-> (cnt_q >= init_q && cnt_q <= mod_q));

  // R3: the working set changes only at a period start
  assert_shadow_R3: assert property (@(posedge clk) disable iff (rst)
    !bnd |=> ($stable(mod_q) && $stable(chv_q) && $stable(init_q)));

  // R8: without a tick the count holds
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt_q));

  // R10: a degenerate range keeps the count at the start value
  assert_degen_R10: assert property (@(posedge clk) disable iff (rst)
    (bnd && mod_in <= init_in) |=> (cnt_q == init_q));
endmodule

// File: rtl/cpwm_compare.sv
module cpwm_compare #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_n,
  input  logic [CNT_W-1:0] chv_n,
  input  logic             desc_n,
  input  logic             inv,
  output logic             pwm_q
);
  logic above;

  always_comb above = (cnt_n > chv_n) || ((cnt_n == chv_n) && desc_n);

  always_ff @(posedge clk) begin
    if (rst) pwm_q <= 1'b0;
    else     pwm_q <= above ^ inv;
  end

  // R6: with the count frozen, a sense flip moves the pin
  assert_sense_R6: assert property (@(posedge clk) disable iff (rst)
    (inv != $past(inv) && cnt_n == $past(cnt_n) && chv_n == $past(chv_n)
     && desc_n == $past(desc_n)) |=> (pwm_q != $past(pwm_q)));
endmodule

// File: rtl/cpwm_timer.sv
module cpwm_timer #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       clk_sel,
  input  logic             ext_tick,
  input  logic [PSC_W-1:0] presc,
  input  logic [CNT_W-1:0] cnt_init,
  input  logic [CNT_W-1:0] mod_val,
  input  logic [CNT_W-1:0] ch_val,
  input  logic             pol_inv,
  input  logic             trig_en,
  input  logic             tof_clr,
  output logic [CNT_W-1:0] count,
  output logic             pwm_out,
  output logic             init_trig,
  output logic             tof
);
  import cpwm_pkg::*;

  clk_src_e         src_sel;
  logic             run, src_pulse, tick, bnd, desc_n;
  logic [CNT_W-1:0] cnt_q, init_q, mod_q, chv_q, cnt_n, chv_n;

  always_comb begin
    src_sel = clk_src_e'(clk_sel);
    run     = (src_sel != CS_OFF);
    unique case (src_sel)
      CS_SYS:            src_pulse = 1'b1;
      CS_EXT, CS_EXT_ALT: src_pulse = ext_tick;
      default:           src_pulse = 1'b0;
    endcase
  end

  cpwm_prescale #(.PSC_W(PSC_W)) u_presc (
    .clk(clk), .rst(rst), .run(run), .src_pulse(src_pulse),
    .presc(presc), .tick(tick)
  );

  cpwm_updown #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick),
    .init_in(cnt_init), .mod_in(mod_val), .chv_in(ch_val),
    .cnt_q(cnt_q), .init_q(init_q), .mod_q(mod_q), .chv_q(chv_q),
    .cnt_n(cnt_n), .chv_n(chv_n), .desc_n(desc_n), .bnd(bnd)
  );

  cpwm_compare #(.CNT_W(CNT_W)) u_cmp (
    .clk(clk), .rst(rst), .cnt_n(cnt_n), .chv_n(chv_n),
    .desc_n(desc_n), .inv(pol_inv), .pwm_q(pwm_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      init_trig <= 1'b0;
      tof       <= 1'b0;
    end else begin
      init_trig <= bnd && trig_en;
      if (bnd)          tof <= 1'b1;
      else if (tof_clr) tof <= 1'b0;
    end
  end

  assign count = cnt_q;

  // R4: the pulse coincides with the start value on the count
  assert_trig_at_start_R4: assert property (@(posedge clk) disable iff (rst)
    init_trig |-> (count == init_q));

  // R4: no pulse while disabled
  assert_trig_gated_R4: assert property (@(posedge clk) disable iff (rst)
    !trig_en |=> !init_trig);

  // R7: a period start always leaves the flag set, even against a clear
  assert_tof_set_R7: assert property (@(posedge clk) disable iff (rst)
    bnd |=> tof);

  // R7: a clear without a period start empties the flag
  assert_tof_clr_R7: assert property (@(posedge clk) disable iff (rst)
    (tof_clr && !bnd) |=> !tof);

  // R5: a threshold at or above the ceiling keeps the pin low
  assert_low_chv_ge_mod_R5: assert property (@(posedge clk) disable iff (rst)
    (chv_q >= mod_q && mod_q > init_q && !$past(pol_inv)) |-> !pwm_out);

  // R8: stopped timer holds the count
  assert_stop_R8: assert property (@(posedge clk) disable iff (rst)
    (src_sel == CS_OFF) |=> $stable(count));
endmodule

// File: tb/test_cpwm_timer.sv
module test_cpwm_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  clk_sel = 2'b00;
  logic        ext_tick = 1'b0;
  logic [2:0]  presc = 3'd0;
  logic [15:0] cnt_init = 16'd0, mod_val = 16'd0, ch_val = 16'd0;
  logic        pol_inv = 1'b0, trig_en = 1'b0, tof_clr = 1'b0;
  logic [15:0] count;
  logic        pwm_out, init_trig, tof;

  int checks = 0;
  int errors = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cpwm_timer i_cpwm_timer (
    .clk(clk), .rst(rst), .clk_sel(clk_sel), .ext_tick(ext_tick),
    .presc(presc), .cnt_init(cnt_init), .mod_val(mod_val), .ch_val(ch_val),
    .pol_inv(pol_inv), .trig_en(trig_en), .tof_clr(tof_clr),
    .count(count), .pwm_out(pwm_out), .init_trig(init_trig), .tof(tof)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  // period-phase reference model
  int e_cnt, e_pwm, e_trig, e_tof;
  int m_phase, m_div, sM, sC, sI;
  bit m_started;

  function automatic int period_len(input int m, input int i);
    return (m > i) ? 2 * (m - i) : 1;
  endfunction

  always @(posedge clk) begin
    bit src, tk, bd, desc;
    int lim, half;
    if (rst) begin
      m_started = 0; m_phase = 0; m_div = 0; sM = 0; sC = 0; sI = 0;
      e_cnt = 0; e_pwm = 0; e_trig = 0; e_tof = 0;
    end else begin
      src = (clk_sel == 2'b01) || (clk_sel[1] && ext_tick);
      tk = 0;
      if (clk_sel == 2'b00) m_div = 0;
      else if (src) begin
        lim = (1 << presc) - 1;
        if (m_div >= lim) begin tk = 1; m_div = 0; end
        else m_div++;
      end
      bd = 0;
      if (tk) begin
        if (!m_started || m_phase + 1 >= period_len(sM, sI)) begin
          m_started = 1; m_phase = 0; bd = 1;
          sM = int'(mod_val); sC = int'(ch_val); sI = int'(cnt_init);
        end else m_phase++;
      end
      desc = 0;
      if (!m_started) e_cnt = 0;
      else if (sM > sI) begin
        half = sM - sI;
        e_cnt = (m_phase <= half) ? sI + m_phase : sI + 2 * half - m_phase;
        desc = (m_phase > half);
      end else e_cnt = sI;
      e_pwm = (((e_cnt > sC) || (e_cnt == sC && desc)) ? 1 : 0) ^ int'(pol_inv);
      e_trig = (bd && trig_en) ? 1 : 0;
      if (bd) e_tof = 1;
      else if (tof_clr) e_tof = 0;
    end
  end

  always @(negedge clk) begin
    if (mon_on && !rst) begin
      chk("R2 count", int'(count), e_cnt);
      chk("R5/R6 pwm_out", int'(pwm_out), e_pwm);
      chk("R4 init_trig", int'(init_trig), e_trig);
      chk("R7 tof", int'(tof), e_tof);
    end
  end

  task automatic wait_trig();
    do @(negedge clk); while (!init_trig);
  endtask

  task automatic measure_period(input int exp_len, input int exp_high, input string tag);
    int n, hi;
    wait_trig();
    n = 0; hi = 0;
    do begin
      @(negedge clk);
      n++;
      hi += int'(pwm_out);
    end while (!init_trig && n < 5000);
    chk({tag, " period length"}, n, exp_len);
    chk({tag, " high cycles"}, hi, exp_high);
  endtask

  task automatic set_cfg(input int i, input int m, input int c);
    cnt_init = 16'(i); mod_val = 16'(m); ch_val = 16'(c);
  endtask

  initial begin
    int n, trigs, held;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 count", int'(count), 0);
    chk("R1 pwm_out", int'(pwm_out), 0);
    chk("R1 init_trig", int'(init_trig), 0);
    chk("R1 tof", int'(tof), 0);
    rst = 1'b0;
    mon_on = 1'b1;

    // R2 R5: ceiling 300, threshold 200
    set_cfg(0, 300, 200); trig_en = 1'b1; clk_sel = 2'b01;
    measure_period(600, 200, "R2 R5");

    // R3: mid-period rewrite keeps the running period
    wait_trig();
    repeat (100) @(negedge clk);
    set_cfg(0, 100, 50);
    n = 100;
    do begin @(negedge clk); n++; end while (!init_trig && n < 5000);
    chk("R3 running period kept", n, 600);
    measure_period(200, 100, "R3 new period");

    // R6: inverted sense
    ch_val = 16'd80; pol_inv = 1'b1;
    wait_trig();
    measure_period(200, 160, "R6");

    // R5: threshold at or above ceiling
    pol_inv = 1'b0; ch_val = 16'd150;
    wait_trig();
    measure_period(200, 0, "R5 chv>=mod");

    // R4: pulse disabled
    trig_en = 1'b0; trigs = 0;
    repeat (600) begin @(negedge clk); trigs += int'(init_trig); end
    chk("R4 no pulse when disabled", trigs, 0);
    trig_en = 1'b1;

    // R7: set wins over a simultaneous clear
    tof_clr = 1'b1;
    wait_trig();
    chk("R7 set wins", int'(tof), 1);
    @(negedge clk);
    chk("R7 cleared", int'(tof), 0);
    tof_clr = 1'b0;
    wait_trig();
    repeat (5) @(negedge clk);
    chk("R7 sticky", int'(tof), 1);

    // R8: stopped
    clk_sel = 2'b00;
    @(negedge clk);
    held = int'(count);
    repeat (50) @(negedge clk);
    chk("R8 stopped hold", int'(count), held);
    // R8: external source with no pulses
    clk_sel = 2'b10;
    repeat (30) @(negedge clk);
    chk("R8 ext idle hold", int'(count), held);
    repeat (200) begin ext_tick = 1'(($urandom % 3) == 0); @(negedge clk); end
    ext_tick = 1'b0;

    // R9: prescaler divide by 4
    clk_sel = 2'b01; presc = 3'd2; set_cfg(0, 10, 5);
    wait_trig();
    measure_period(80, 40, "R9");
    presc = 3'd0;

    // R10: ceiling below start
    set_cfg(7, 5, 3);
    wait_trig(); wait_trig();
    repeat (5) begin
      @(negedge clk);
      chk("R10 pulse each tick", int'(init_trig), 1);
      chk("R10 count at start", int'(count), 7);
    end

    // seeded random segments
    for (int s = 0; s < 40; s++) begin
      clk_sel = 2'($urandom % 4);
      presc = 3'($urandom % 3);
      set_cfg($urandom % 8, $urandom % 40, $urandom % 40);
      pol_inv = 1'($urandom % 2);
      trig_en = 1'($urandom % 2);
      for (int c = 0; c < 300; c++) begin
        ext_tick = 1'($urandom % 2);
        tof_clr = 1'(($urandom % 8) == 0);
        if (c == 150) set_cfg($urandom % 8, $urandom % 40, $urandom % 40);
        @(negedge clk);
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired got 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule